// File: doc/BRIEF.md
# Pixel Readout Frame Stream Generator

This block stands in for a pixel-chip readout link on a test bench. Every clock it puts out one 16-bit word, with two side strobes that say whether the word is a control word or a data word. Words come in fixed four-word frames. The first two words of a frame are control words and the last two are data words. Between readouts the generator sends idle frames. After a trigger it plays one readout sequence: a few idle frames, one event frame, then a run of hit frames. The hit frames carry an incrementing data pattern, so a receiver can check the order of the words it gets.

There are two trigger modes. In normal mode a trigger starts the sequence from its first word at the next frame boundary. In stepped mode the generator loops over the opening words of the sequence until a trigger arrives. It then finishes the current loop and carries on from the word after the loop. An 8-bit event number is stamped into every frame. It advances each time a sequence completes.

Top module: `pixel_frame_gen`

## Requirements
- R1: While reset is held, and straight after it, the output is slot 0 of an idle frame with event number 0: wordOut = 0x0000, cavOut = 1, davOut = 0.
- R2: Words are grouped in frames of four. Slots 0 and 1 drive cavOut = 1 and davOut = 0. Slots 2 and 3 drive cavOut = 0 and davOut = 1.
- R3: An idle frame has these words. Slot 0 carries frame kind 00 in bits 9:8 and the event number in bits 7:0. Slot 1 is 0x0000. Both data slots are 0xFFFF. Idle frames are sent whenever no sequence is running.
- R4: A sequence is 1040 words: 3 idle frames (frames 0 to 2), the event frame (frame 3), and 256 hit frames (frames 4 to 259). In the event frame and in every hit frame, slot 1 holds the frame number.
- R5: The event frame's slot 0 carries kind 01 in bits 9:8 and the event number in bits 7:0. Its slot 2 holds the event number. Its slot 3 holds the number of hit data words, 512.
- R6: Hit frame h (counting from 0) carries kind 10 in bits 9:8 of slot 0. Its two data words are 2h and 2h+1, so the data words run 0 to 511 in order.
- R7: Bits 13:12 of slot 0 are both set in the first hit frame only. Bits 11:10 of slot 0 are both set in the last hit frame only. These are the first-word and last-word marks (bits 29:28 and 27:26 of the 32-bit control pair).
- R8: In normal mode, a trigger seen at any rising edge while idle is remembered. The sequence begins with its word 0 directly after the next slot-3 word. A trigger seen at the edge that ends slot 3 starts the sequence on the very next word.
- R9: In stepped mode, the idle generator loops over sequence words 0 to 7. After a trigger, the loop is finished and output continues at word 8.
- R10: Triggers are ignored while a sequence runs. After the last word, idle frames resume from slot 0, and the event number has advanced by one (modulo 256).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one word per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| trigger | input | 1 | Readout request, sampled on rising edges |
| steppedMode | input | 1 | 1 selects the looping preamble mode |
| wordOut | output | 16 | Current stream word |
| cavOut | output | 1 | High for control words |
| davOut | output | 1 | High for data words |

## Verification
The bench builds the generator with its default parameters: 3 idle frames, 256 hit frames and an 8-word preamble. It therefore sees the whole 1040-word sequence, including frame 259 carrying the last-word mark and data words 510 and 511 at the top of the count. With these defaults the two modes differ in a way the outputs show. After a stepped-mode trigger, only one idle frame comes before the event frame, where normal mode gives three. A trigger timed exactly on a slot-3 edge shows whether the start waits an extra frame. The event number is followed across three sequences and a mid-run reset.

// File: rtl/pixgen_pkg.sv
package pixgen_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'b00,
    KIND_EVENT = 2'b01,
    KIND_HIT   = 2'b10
  } frameKind_t;

  // strobes passed from the sequencer to the word builder
  typedef struct packed {
    frameKind_t  kind;
    logic [1:0]  slot;
    logic [15:0] frameNum;
    logic        firstHit;
    logic        lastHit;
    logic        seqDone;
  } genStrobe_t;

endpackage

// File: rtl/pixgen_ctrl.sv
module pixgen_ctrl
  import pixgen_pkg::*;
#(
  parameter int IDLE_FRAMES = 3,
  parameter int HIT_FRAMES  = 256,
  parameter int PRE_WORDS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  logic       steppedMode,
  output genStrobe_t strb
);

  localparam int TOTAL = 4 * (IDLE_FRAMES + 1 + HIT_FRAMES);
  localparam int POS_W = $clog2(TOTAL);
  localparam int FR_W  = POS_W - 2;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOTAL - 1);
  localparam logic [POS_W-1:0] PRE_LAST = POS_W'(PRE_WORDS - 1);
  localparam logic [POS_W-1:0] PRE_NEXT = POS_W'(PRE_WORDS);
  localparam logic [FR_W-1:0]  EVT_FR   = FR_W'(IDLE_FRAMES);
  localparam logic [FR_W-1:0]  FIRST_FR = FR_W'(IDLE_FRAMES + 1);
  localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(IDLE_FRAMES + HIT_FRAMES);

  logic [POS_W-1:0] wordPos;
  logic             running;
  logic             pendingQ;
  logic             go;
  logic             lastWord;
  logic [FR_W-1:0]  frameIdx;

  assign go       = pendingQ | trigger;
  assign lastWord = running && (wordPos == LAST_POS);
  assign frameIdx = wordPos[POS_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPos  <= '0;
      running  <= 1'b0;
      pendingQ <= 1'b0;
    end else if (running) begin
      if (lastWord) begin
        running <= 1'b0;
        wordPos <= '0;
      end else begin
        wordPos <= wordPos + 1'b1;
      end
    end else if (steppedMode) begin
      if (wordPos == PRE_LAST) begin
        if (go) begin
          running  <= 1'b1;
          wordPos  <= PRE_NEXT;
          pendingQ <= 1'b0;
        end else begin
          wordPos <= '0;
        end
      end else begin
        wordPos  <= wordPos + 1'b1;
        pendingQ <= go;
      end
    end else begin
      if (wordPos[1:0] == 2'd3) begin
        wordPos <= '0;
        if (go) begin
          running  <= 1'b1;
          pendingQ <= 1'b0;
        end
      end else begin
        wordPos  <= wordPos + 1'b1;
        pendingQ <= go;
      end
    end
  end

  always_comb begin
    strb.slot     = wordPos[1:0];
    strb.frameNum = 16'(frameIdx);
    strb.firstHit = (frameIdx == FIRST_FR);
    strb.lastHit  = (frameIdx == LAST_FR);
    strb.seqDone  = lastWord;
    if (frameIdx < EVT_FR)       strb.kind = KIND_IDLE;
    else if (frameIdx == EVT_FR) strb.kind = KIND_EVENT;
    else                         strb.kind = KIND_HIT;
  end

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    wordPos <= LAST_POS);

  assert_rest_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> wordPos < 8);

  assert_no_pending_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !pendingQ);

  assert_back_to_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    lastWord |=> (!running && wordPos == '0));

  assert_normal_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !steppedMode && wordPos[1:0] == 2'd3 && trigger)
      |=> (running && wordPos == '0));

  assert_stepped_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && steppedMode && wordPos == PRE_LAST && trigger)
      |=> (running && wordPos == PRE_NEXT));

endmodule

// File: rtl/pixgen_datapath.sv
module pixgen_datapath
  import pixgen_pkg::*;
#(
  parameter int          IDLE_FRAMES = 3,
  parameter int          HIT_FRAMES  = 256,
  parameter logic [15:0] NO_DATA     = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  genStrobe_t  strb,
  output logic [15:0] wordOut,
  output logic        cavOut,
  output logic        davOut
);

  localparam logic [15:0] FIRST_HIT = 16'(IDLE_FRAMES + 1);
  localparam logic [15:0] HIT_WORDS = 16'(2 * HIT_FRAMES);

  logic [7:0]  eventNum;
  logic [15:0] hitWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             eventNum <= '0;
    else if (strb.seqDone) eventNum <= eventNum + 8'd1;
  end

  assign hitWord = ((strb.frameNum - FIRST_HIT) << 1) | 16'(strb.slot[0]);

  always_comb begin
    unique case (strb.slot)
      2'd0: wordOut = {2'b00, {2{strb.firstHit}}, {2{strb.lastHit}},
                       strb.kind, eventNum};
      2'd1: wordOut = (strb.kind == KIND_IDLE) ? 16'h0000 : strb.frameNum;
      default: begin
        unique case (strb.kind)
          KIND_IDLE:  wordOut = NO_DATA;
          KIND_EVENT: wordOut = (strb.slot == 2'd2) ? {8'h00, eventNum} : HIT_WORDS;
          default:    wordOut = hitWord;
        endcase
      end
    endcase
  end

  assign cavOut = ~strb.slot[1];
  assign davOut = strb.slot[1];

  assert_hit_odd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.kind == KIND_HIT && strb.slot == 2'd3) |-> wordOut[0]);

  assert_first_in_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.firstHit || strb.lastHit) |-> strb.kind == KIND_HIT);

  assert_done_on_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqDone |-> (davOut && !cavOut));

endmodule

// File: rtl/pixel_frame_gen.sv
module pixel_frame_gen
  import pixgen_pkg::*;
#(
  parameter int          IDLE_FRAMES = 3,
  parameter int          HIT_FRAMES  = 256,
  parameter int          PRE_WORDS   = 8,
  parameter logic [15:0] NO_DATA     = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        steppedMode,
  output logic [15:0] wordOut,
  output logic        cavOut,
  output logic        davOut
);

  genStrobe_t strb;

  pixgen_ctrl #(
    .IDLE_FRAMES(IDLE_FRAMES),
    .HIT_FRAMES (HIT_FRAMES),
    .PRE_WORDS  (PRE_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigger    (trigger),
    .steppedMode(steppedMode),
    .strb       (strb)
  );

  pixgen_datapath #(
    .IDLE_FRAMES(IDLE_FRAMES),
    .HIT_FRAMES (HIT_FRAMES),
    .NO_DATA    (NO_DATA)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wordOut(wordOut),
    .cavOut (cavOut),
    .davOut (davOut)
  );

endmodule

// File: tb/tb_pixel_frame_gen.sv
`timescale 1ns/1ps
module tb_pixel_frame_gen;

  localparam int IDLE_N = 3;
  localparam int HIT_N  = 256;
  localparam int SEQ_N  = 4 * (IDLE_N + 1 + HIT_N);

  // {word index, expected word} for a sequence carrying event number 0
  localparam int VEC_N = 16;
  localparam logic [31:0] VEC [VEC_N] = '{
    {16'd0,    16'h0000}, {16'd2,    16'hFFFF}, {16'd12,   16'h0100},
    {16'd13,   16'h0003}, {16'd14,   16'h0000}, {16'd15,   16'h0200},
    {16'd16,   16'h3200}, {16'd17,   16'h0004}, {16'd18,   16'h0000},
    {16'd19,   16'h0001}, {16'd20,   16'h0200}, {16'd23,   16'h0003},
    {16'd1036, 16'h0E00}, {16'd1037, 16'h0103}, {16'd1038, 16'h01FE},
    {16'd1039, 16'h01FF}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        trigger;
  logic        steppedMode;
  logic [15:0] wordOut;
  logic        cavOut;
  logic        davOut;

  int total = 0;
  int bad   = 0;
  logic [17:0] cap [SEQ_N];

  always #4 clk = ~clk;

  pixel_frame_gen #(
    .IDLE_FRAMES(IDLE_N),
    .HIT_FRAMES (HIT_N),
    .PRE_WORDS  (8),
    .NO_DATA    (16'hFFFF)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .trigger    (trigger),
    .steppedMode(steppedMode),
    .wordOut    (wordOut),
    .cavOut     (cavOut),
    .davOut     (davOut)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input int n, input int evt);
    int fr = n / 4;
    int sl = n % 4;
    logic [1:0] kd = (fr < IDLE_N) ? 2'b00 : (fr == IDLE_N) ? 2'b01 : 2'b10;
    logic f = (fr == IDLE_N + 1);
    logic l = (fr == IDLE_N + HIT_N);
    if (sl == 0) return {2'b00, {2{f}}, {2{l}}, kd, 8'(evt)};
    if (sl == 1) return (fr < IDLE_N) ? 16'h0000 : 16'(fr);
    if (fr < IDLE_N) return 16'hFFFF;
    if (fr == IDLE_N) return (sl == 2) ? 16'(evt & 255) : 16'(2 * HIT_N);
    return 16'(2 * (fr - IDLE_N - 1) + sl - 2);
  endfunction

  function automatic logic [1:0] expSide(input int n);
    return ((n % 4) < 2) ? 2'b10 : 2'b01;
  endfunction

  function automatic string tagOf(input int n);
    int fr = n / 4;
    if (fr < IDLE_N) return "R3";
    if (fr == IDLE_N) return "R5";
    if ((n % 4) == 0) return "R7";
    return "R6";
  endfunction

  // sample words first..last-1, one per clock; a trigger is pulsed at word poke
  task automatic captureRun(input int first, input int last, input int poke);
    for (int n = first; n < last; n++) begin
      cap[n] = {cavOut, davOut, wordOut};
      trigger = (n == poke);
      @(negedge clk);
    end
    trigger = 1'b0;
  endtask

  task automatic checkRun(input int first, input int last, input int evt);
    for (int n = first; n < last; n++) begin
      chk(tagOf(n), {2'b00, cap[n][15:0]}, {2'b00, expWord(n, evt)});
      chk("R2", {16'h0, cap[n][17:16]}, {16'h0, expSide(n)});
    end
  endtask

  task automatic checkRest(input int evt, input int count, input string req);
    for (int k = 0; k < count; k++) begin
      chk(req, {cavOut, davOut, wordOut}, {expSide(k), expWord(k % 4, evt)});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; trigger = 1'b0; steppedMode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {cavOut, davOut, wordOut}, {2'b10, 16'h0000});
    rstN = 1'b1;

    // normal mode: trigger remembered mid-frame, start after slot 3
    @(negedge clk);
    chk("R3", {cavOut, davOut, wordOut}, {2'b10, 16'h0000});
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk("R3", {cavOut, davOut, wordOut}, {2'b01, 16'hFFFF});
    @(negedge clk);
    @(negedge clk);
    captureRun(0, SEQ_N, 100);          // trigger at word 100 must be ignored (R10)
    for (int v = 0; v < VEC_N; v++)
      chk("R4", {2'b00, cap[int'(VEC[v][31:16])][15:0]}, {2'b00, VEC[v][15:0]});
    checkRun(0, SEQ_N, 0);
    checkRest(1, 16, "R10");            // idle resumes, event number now 1

    // stepped mode: loop of eight words, trigger jumps to word 8
    steppedMode = 1'b1;
    checkRest(1, 16, "R9");
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (6) @(negedge clk);
    captureRun(8, SEQ_N, -1);
    chk("R9", {2'b00, cap[12][15:0]}, {2'b00, 16'h0101});
    checkRun(8, SEQ_N, 1);
    chk("R10", {cavOut, davOut, wordOut}, {2'b10, 16'h0002});

    // normal mode: trigger exactly on the slot-3 edge starts at once (R8)
    steppedMode = 1'b0;
    repeat (3) @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    captureRun(0, 600, -1);
    chk("R8", {2'b00, cap[12][15:0]}, {2'b00, 16'h0102});
    checkRun(0, 600, 2);

    // reset during a sequence clears position and event number
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", {cavOut, davOut, wordOut}, {2'b10, 16'h0000});
    rstN = 1'b1;
    checkRest(0, 8, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule